// File: doc/BRIEF.md
# Timer Input Capture Conditioning Channel

This block is a single input-capture channel for a general-purpose timer. An asynchronous channel pin is brought into the clock domain by a two-stage synchronizer. A programmable digital noise filter follows. A level is accepted only after a set number of consecutive samples all disagree with the current filtered level. Samples are taken either on every clock or on a divided sampling clock derived from pulses on `tick_en`.

On the filtered signal, a polarity bit selects whether rising or falling transitions count as edges. Qualifying edges feed a capture prescaler that lets through every 1st, 2nd, 4th or 8th edge. Each edge that passes copies the free-running counter value `cnt_val` into the capture register and raises a sticky capture flag. If the flag is still set when a new capture happens, an overcapture flag is raised as well.

The timer counter itself lives outside the block. So do interrupt and request generation.

Top module: `icap_channel`

## Requirements
- R1: With `filt_code` = 0 the filter is bypassed. A new level on `ch_in`, driven between clock edges, appears on `filt_out` after the third rising clock edge that follows it.
- R2: Codes 1, 2 and 3 sample on every clock and need 2, 4 and 8 consecutive differing samples respectively. A new level appears on `filt_out` after edge N+2, and a pulse lasting N-1 clocks is rejected.
- R3: Codes 4 to 15 sample once every P pulses of `tick_en` and need N differing samples. The (P, N) pairs by code are: 4:(2,6) 5:(2,8) 6:(4,6) 7:(4,8) 8:(8,6) 9:(8,8) 10:(16,5) 11:(16,6) 12:(16,8) 13:(32,5) 14:(32,6) 15:(32,8). A pulse of (N-1)·P clocks with `tick_en` held high is rejected. A level held for (N+1)·P+3 clocks is accepted. While `tick_en` is low, the filtered level does not move.
- R4: `edge_fall` = 0 counts rising edges of the filtered signal and `edge_fall` = 1 counts falling edges. The other direction is ignored.
- R5: `psc_code` values 0, 1, 2 and 3 make a capture on every 1st, 2nd, 4th and 8th qualifying edge.
- R6: While `ch_en` is low, no capture happens and the prescaler edge count is held at zero. The first capture after re-enabling therefore needs a full prescaler period of edges.
- R7: A capture loads `cap_val` with the `cnt_val` present at the clock edge that follows the filtered transition. In bypass this is the fourth edge after the `ch_in` change.
- R8: A capture sets `cap_flag`, and also sets `ovr_flag` if `cap_flag` was already set. `flag_clr` clears both flags. When a capture and `flag_clr` coincide, the result is `cap_flag` = 1 and `ovr_flag` = 0.
- R9: After reset, `cap_val` is 0 and `cap_flag`, `ovr_flag` and `filt_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_in | input | 1 | Asynchronous channel input |
| ch_en | input | 1 | Channel enable; low holds the prescaler cleared |
| edge_fall | input | 1 | 0: count rising edges, 1: count falling edges |
| filt_code | input | 4 | Filter selection (rate and sample count) |
| psc_code | input | 2 | Capture prescaler selection |
| tick_en | input | 1 | Base pulse for the divided sampling clock |
| cnt_val | input | CW | Free-running counter value |
| flag_clr | input | 1 | Clears capture and overcapture flags |
| cap_val | output | CW | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| ovr_flag | output | 1 | Sticky overcapture flag |
| filt_out | output | 1 | Filtered channel level |

## Verification
The assertions assume that every input except `ch_in` is synchronous to `clk`. They also assume that `filt_code` is changed only while the channel is quiet, because a code change in the middle of a partial sample count is not modelled as a separate case. The stimulus drives all inputs on the falling clock edge and sets `filt_code` only during or right after reset. The randomised phase uses bypass mode, so that a cycle-exact reference of prescaler, polarity, enable and flag interplay applies. The filter codes are covered by directed pulses sized exactly at the rejection and acceptance bounds.

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_in,
  input  logic          ch_en,
  input  logic          edge_fall,
  input  logic [3:0]    filt_code,
  input  logic [1:0]    psc_code,
  input  logic          tick_en,
  input  logic [CW-1:0] cnt_val,
  input  logic          flag_clr,
  output logic [CW-1:0] cap_val,
  output logic          cap_flag,
  output logic          ovr_flag,
  output logic          filt_out
);

  localparam int DW = 5;

  logic [1:0]    sync;
  logic [DW-1:0] dcnt;
  logic [3:0]    fcnt;
  logic          filt, filt_d;
  logic [2:0]    pcnt;
  logic          clk_rate;
  logic [2:0]    dlog;
  logic [3:0]    nreq;

  wire           s_in   = sync[1];
  wire           bypass = (filt_code == 4'd0);
  wire [DW-1:0]  mask   = (DW'(1) << dlog) - DW'(1);
  wire           smp    = clk_rate | (tick_en & ((dcnt | ~mask) == {DW{1'b1}}));
  wire [3:0]     plim   = (4'd1 << psc_code) - 4'd1;
  wire           hit    = edge_fall ? (~filt & filt_d) : (filt & ~filt_d);
  wire           evt    = ch_en & hit & ({1'b0, pcnt} == plim);

  always_comb begin
    clk_rate = 1'b0;
    dlog     = 3'd0;
    nreq     = 4'd0;
    case (filt_code)
      4'd1:  begin clk_rate = 1'b1; nreq = 4'd2; end
      4'd2:  begin clk_rate = 1'b1; nreq = 4'd4; end
      4'd3:  begin clk_rate = 1'b1; nreq = 4'd8; end
      4'd4:  begin dlog = 3'd1; nreq = 4'd6; end
      4'd5:  begin dlog = 3'd1; nreq = 4'd8; end
      4'd6:  begin dlog = 3'd2; nreq = 4'd6; end
      4'd7:  begin dlog = 3'd2; nreq = 4'd8; end
      4'd8:  begin dlog = 3'd3; nreq = 4'd6; end
      4'd9:  begin dlog = 3'd3; nreq = 4'd8; end
      4'd10: begin dlog = 3'd4; nreq = 4'd5; end
      4'd11: begin dlog = 3'd4; nreq = 4'd6; end
      4'd12: begin dlog = 3'd4; nreq = 4'd8; end
      4'd13: begin dlog = 3'd5; nreq = 4'd5; end
      4'd14: begin dlog = 3'd5; nreq = 4'd6; end
      4'd15: begin dlog = 3'd5; nreq = 4'd8; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b00;
    else        sync <= {sync[0], ch_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       dcnt <= '0;
    else if (tick_en) dcnt <= dcnt + DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= 1'b0;
      fcnt <= 4'd0;
    end else if (bypass) begin
      filt <= s_in;
      fcnt <= 4'd0;
    end else if (smp) begin
      if (s_in == filt) begin
        fcnt <= 4'd0;
      end else if (fcnt + 4'd1 == nreq) begin
        filt <= s_in;
        fcnt <= 4'd0;
      end else begin
        fcnt <= fcnt + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) filt_d <= 1'b0;
    else        filt_d <= filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= 3'd0;
    else if (!ch_en) pcnt <= 3'd0;
    else if (hit)    pcnt <= evt ? 3'd0 : pcnt + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (evt) cap_val <= cnt_val;
      cap_flag <= evt | (cap_flag & ~flag_clr);
      ovr_flag <= (ovr_flag | (evt & cap_flag)) & ~flag_clr;
    end
  end

  assign filt_out = filt;

  p_cap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cap_val == $past(cnt_val));
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cap_flag);
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cap_flag && !flag_clr) |=> ovr_flag);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !evt) |=> (!cap_flag && !ovr_flag));
  p_ovr_needs_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> cap_flag);
  p_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> ($stable(cap_val) && pcnt == 3'd0));
  p_no_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !smp) |=> $stable(filt));

endmodule

// File: tb/test_icap_channel.sv
module test_icap_channel;
  localparam int CLK_P = 10;
  localparam int CW    = 16;

  logic clk = 0, rst_n = 0, ch_in = 0, ch_en = 0, edge_fall = 0, tick_en = 0, flag_clr = 0;
  logic [3:0]    filt_code = 0;
  logic [1:0]    psc_code  = 0;
  logic [CW-1:0] cnt_val   = 0;
  logic [CW-1:0] cap_val;
  logic          cap_flag, ovr_flag, filt_out;
  int checks = 0, errors = 0;

  logic m_s1, m_s2, m_f, m_fp, m_cap, m_ovr;
  logic [2:0] m_pc;
  logic [CW-1:0] m_val;

  always #(CLK_P/2) clk = ~clk;

  icap_channel #(.CW(CW)) i_icap_channel (
    .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .ch_en(ch_en), .edge_fall(edge_fall),
    .filt_code(filt_code), .psc_code(psc_code), .tick_en(tick_en), .cnt_val(cnt_val),
    .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag),
    .filt_out(filt_out));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int per_of(logic [3:0] c);
    case (c)
      4'd4, 4'd5: return 2;
      4'd6, 4'd7: return 4;
      4'd8, 4'd9: return 8;
      4'd10, 4'd11, 4'd12: return 16;
      4'd13, 4'd14, 4'd15: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic int n_of(logic [3:0] c);
    case (c)
      4'd1: return 2;
      4'd2: return 4;
      4'd10, 4'd13: return 5;
      4'd4, 4'd6, 4'd8, 4'd11, 4'd14: return 6;
      default: return 8;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 0; ch_in = 0; ch_en = 0; edge_fall = 0; tick_en = 0; flag_clr = 0;
    filt_code = 0; psc_code = 0; cnt_val = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_s1 = 0; m_s2 = 0; m_f = 0; m_fp = 0; m_cap = 0; m_ovr = 0; m_pc = 0; m_val = 0;
  endtask

  task automatic cyc(logic vin, logic ven, logic vpol, logic [1:0] vpsc, logic vclr, string tag);
    logic hit, evt;
    logic [CW-1:0] vcnt;
    vcnt = CW'($urandom);
    ch_in = vin; ch_en = ven; edge_fall = vpol; psc_code = vpsc; flag_clr = vclr; cnt_val = vcnt;
    @(negedge clk);
    hit = vpol ? (!m_f && m_fp) : (m_f && !m_fp);
    evt = 0;
    if (!ven) m_pc = 0;
    else if (hit) begin
      if (m_pc == 3'((1 << vpsc) - 1)) begin evt = 1; m_pc = 0; end
      else m_pc = m_pc + 3'd1;
    end
    if (vclr) begin m_cap = 0; m_ovr = 0; end
    if (evt) begin m_ovr = m_ovr | m_cap; m_cap = 1; m_val = vcnt; end
    m_fp = m_f; m_f = m_s2; m_s2 = m_s1; m_s1 = vin;
    chk({tag, " cap_val"}, 32'(cap_val), 32'(m_val));
    chk({tag, " cap_flag"}, 32'(cap_flag), 32'(m_cap));
    chk({tag, " ovr_flag"}, 32'(ovr_flag), 32'(m_ovr));
    chk({tag, " filt_out"}, 32'(filt_out), 32'(m_f));
  endtask

  task automatic filt_test(logic [3:0] code);
    int p, n, w;
    logic seen;
    do_reset();
    filt_code = code; tick_en = 1;
    p = per_of(code); n = n_of(code);
    w = (n - 1) * p;
    repeat (80) @(negedge clk);
    seen = 0;
    ch_in = 1;
    repeat (w) begin @(negedge clk); seen |= filt_out; end
    ch_in = 0;
    repeat (2 * p + 70) begin @(negedge clk); seen |= filt_out; end
    chk($sformatf("R2/R3 reject code %0d", code), 32'(seen), 0);
    ch_in = 1;
    if (code <= 4'd3) begin
      repeat (n + 1) @(negedge clk);
      chk($sformatf("R2 early code %0d", code), 32'(filt_out), 0);
      @(negedge clk);
      chk($sformatf("R2 accept code %0d", code), 32'(filt_out), 1);
    end else begin
      repeat ((n + 1) * p + 3) @(negedge clk);
      chk($sformatf("R3 accept code %0d", code), 32'(filt_out), 1);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c4d));
    do_reset();
    chk("R9 cap_val", 32'(cap_val), 0);
    chk("R9 cap_flag", 32'(cap_flag), 0);
    chk("R9 ovr_flag", 32'(ovr_flag), 0);
    chk("R9 filt_out", 32'(filt_out), 0);

    // R1 and R7: bypass latency and captured counter value
    ch_en = 1; ch_in = 1; cnt_val = 100;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      cnt_val = cnt_val + 1;
      if (i == 2) chk("R1 before third edge", 32'(filt_out), 0);
      if (i == 3) chk("R1 after third edge", 32'(filt_out), 1);
    end
    chk("R7 cap_val", 32'(cap_val), 103);
    chk("R7 cap_flag", 32'(cap_flag), 1);

    // R4: polarity
    do_reset();
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b1, 2'd0, 1'b0, "R4 rise ignored");
    chk("R4 no capture on rise", 32'(cap_flag), 0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, 2'd0, 1'b0, "R4 fall counted");
    chk("R4 capture on fall", 32'(cap_flag), 1);

    // R6: prescaler cleared by disable
    do_reset();
    for (int e = 0; e < 5; e++) begin
      cyc(1'b1, 1'b1, 1'b0, 2'd3, 1'b0, "R6 pre");
      cyc(1'b1, 1'b1, 1'b0, 2'd3, 1'b0, "R6 pre");
      cyc(1'b0, 1'b1, 1'b0, 2'd3, 1'b0, "R6 pre");
      cyc(1'b0, 1'b1, 1'b0, 2'd3, 1'b0, "R6 pre");
    end
    repeat (6) cyc(1'b0, 1'b0, 1'b0, 2'd3, 1'b0, "R6 off");
    for (int e = 0; e < 7; e++) begin
      cyc(1'b1, 1'b1, 1'b0, 2'd3, 1'b0, "R6 post");
      cyc(1'b1, 1'b1, 1'b0, 2'd3, 1'b0, "R6 post");
      cyc(1'b0, 1'b1, 1'b0, 2'd3, 1'b0, "R6 post");
      cyc(1'b0, 1'b1, 1'b0, 2'd3, 1'b0, "R6 post");
    end
    chk("R6 no capture after 7 edges", 32'(cap_flag), 0);
    repeat (2) cyc(1'b1, 1'b1, 1'b0, 2'd3, 1'b0, "R6 eighth");
    repeat (3) cyc(1'b1, 1'b1, 1'b0, 2'd3, 1'b0, "R6 eighth");
    chk("R6 capture on eighth edge", 32'(cap_flag), 1);

    // R5, R8: random bypass traffic against the reference
    do_reset();
    begin
      logic vin = 0, ven = 1, vpol = 0;
      logic [1:0] vpsc = 0;
      for (int t = 0; t < 4000; t++) begin
        if (t % 400 == 0) begin vpol = 1'($urandom); vpsc = 2'($urandom); end
        if ($urandom_range(0, 3) == 0) vin = ~vin;
        ven = ($urandom_range(0, 60) != 0);
        cyc(vin, ven, vpol, vpsc, ($urandom_range(0, 24) == 0), "R5/R8 random");
      end
    end

    // R8: clear coinciding with a capture
    do_reset();
    repeat (6) cyc(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, "R8 first");
    repeat (3) cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R8 first");
    cyc(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, "R8 second");
    repeat (2) cyc(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, "R8 second");
    cyc(1'b1, 1'b1, 1'b0, 2'd0, 1'b1, "R8 clear with capture");
    chk("R8 simultaneous cap_flag", 32'(cap_flag), 1);
    chk("R8 simultaneous ovr_flag", 32'(ovr_flag), 0);

    // R2, R3: filter codes
    for (int c = 1; c < 16; c++) filt_test(4'(c));

    // R3: sampling frozen while tick_en is low
    do_reset();
    filt_code = 4'd4; tick_en = 0; ch_in = 1;
    repeat (100) @(negedge clk);
    chk("R3 frozen without tick_en", 32'(filt_out), 0);
    tick_en = 1;
    repeat (17) @(negedge clk);
    chk("R3 resumes with tick_en", 32'(filt_out), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule